// File: doc/BRIEF.md
# Memory Controller Performance Counter Unit

This block sits next to a DRAM controller and tallies controller activity in a small bank of counters. The controller delivers one single-cycle pulse line per event kind, and it supplies the transaction ID of the current read and write access. Software programs the counters and reads them back through a plain register port. Each port access is an address, a write strobe and write data, with read data returned combinationally for the presented address.

Counter 0 is the time base. It counts clock cycles whatever selector is written to it, and it is the only counter whose wraparound raises the interrupt line. The remaining counters each pick an event code through an 8-bit selector in their control word. Two of those codes count only the read or write accesses whose transaction ID passes a shared mask-and-compare filter. Counters are `CNT_W` bits wide, 32 by default, and wrap silently. Each counter carries a sticky overflow flag. Writing the control word with its clear bit set zeroes both the count and that flag.

Top module: `mc_perf_counters`

## Requirements
- R1: After reset every counter is zero, disabled and free of overflow, the ID filter register reads zero, and `irq` is low.
- R2: Counter i has its control word at byte address 4·i and its count at byte address 0x20 + 4·i, zero-extended to 32 bits, for i in 0 to NUM_CNT−1. The ID filter sits at 0x30. Every other address, unaligned ones included, reads zero and ignores writes, and writes to the count addresses are ignored.
- R3: Control word layout: bit 0 is the overflow flag (read-only), bit 1 is the clear request (always reads 0), bit 2 is the enable, and bits 31:24 are the event selector. All other bits read 0.
- R4: A control write with bit 1 set zeroes the count and the overflow flag at that edge. Bit 2 of the same write decides whether counting resumes from the next cycle.
- R5: With the enable at 0 the count does not change and stays readable.
- R6: Counter 0 adds one on every enabled cycle regardless of its selector, and its selector field always reads 0x00.
- R7: Counters 1 and up, when enabled, add one per cycle in which the selected line pulses. The codes and lines are: 0x00 every cycle, 0x04 `evt_pulse[0]` (read access), 0x05 `evt_pulse[1]` (write access), 0x20 `evt_pulse[2]` (read command), 0x21 `evt_pulse[3]` (write command), 0x31 `evt_pulse[4]` (precharge), 0x32 `evt_pulse[5]` (activate), 0x37 `evt_pulse[6]` (refresh). Any other code except 0x41 and 0x42 counts nothing.
- R8: The filter word holds an ID value in bits 15:0 and a compare mask in bits 31:16. Code 0x41 counts `evt_pulse[0]` when ((`rd_axi_id` XOR value) AND mask) is zero. Code 0x42 does the same with `evt_pulse[1]` and `wr_axi_id`. A filter write takes effect from the next cycle.
- R9: A count at all ones that increments becomes zero and sets the overflow flag at the same edge. The flag stays set until a control write with bit 1 set.
- R10: `irq` is high for exactly the one cycle after the edge at which counter 0 wraps, and a wrap of any other counter never raises it.
- R11: A control write without bit 1 leaves the count and the overflow flag untouched. The increment in the write cycle follows the enable and selector held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_pulse | input | 7 | Single-cycle event pulses from the controller |
| rd_axi_id | input | ID_W | Transaction ID accompanying a read-access pulse |
| wr_axi_id | input | ID_W | Transaction ID accompanying a write-access pulse |
| irq | output | 1 | One-cycle request on a cycle-counter wrap |

## Verification
The bench narrows the counters so that both counter 0 and a second counter wrap within the run. It confirms that only the cycle counter pulses `irq`, and that the flag on the other counter stays sticky through a non-clearing rewrite. A design that let any overflow drive the interrupt, or that dropped the flag on every control write, would miscompare on the cycle after the write. Random pulses and IDs drawn from a small set run against full, partial and zero filter masks, and against unknown selector codes. This catches a swapped line, an inverted mask or an unknown code that still counts. Control writes that land beside live events, writes to read-only and unaligned addresses, and a write attempting to set the overflow bit expose a design that lets a write disturb the count or lets stray bits leak into readback.

// File: rtl/mcpc_pkg.sv
package mcpc_pkg;

   // number of controller event pulse lines
   localparam int EVT_LINES = 7;

   // pulse line positions
   localparam int LN_RD_ACC = 0;
   localparam int LN_WR_ACC = 1;
   localparam int LN_RD_CMD = 2;
   localparam int LN_WR_CMD = 3;
   localparam int LN_PRECH  = 4;
   localparam int LN_ACTV   = 5;
   localparam int LN_REFR   = 6;

   // event selector codes
   localparam logic [7:0] EC_CYCLES = 8'h00;
   localparam logic [7:0] EC_RD_ACC = 8'h04;
   localparam logic [7:0] EC_WR_ACC = 8'h05;
   localparam logic [7:0] EC_RD_CMD = 8'h20;
   localparam logic [7:0] EC_WR_CMD = 8'h21;
   localparam logic [7:0] EC_PRECH  = 8'h31;
   localparam logic [7:0] EC_ACTV   = 8'h32;
   localparam logic [7:0] EC_REFR   = 8'h37;
   localparam logic [7:0] EC_RD_ID  = 8'h41;
   localparam logic [7:0] EC_WR_ID  = 8'h42;

   // control word bit positions
   localparam int CTL_OVF_BIT = 0;
   localparam int CTL_CLR_BIT = 1;
   localparam int CTL_EN_BIT  = 2;
   localparam int CTL_SEL_LSB = 24;

   // register offsets
   localparam int OFS_VAL_BASE = 'h20;
   localparam int OFS_FILTER   = 'h30;

   // fields carried by one control write
   typedef struct packed {
      logic [7:0] sel;
      logic       en;
      logic       clr;
   } ctl_wr_t;

endpackage

// File: rtl/mcpc_id_filter.sv
module mcpc_id_filter #(
   parameter int ID_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [31:0]     wdata,
   input  logic [ID_W-1:0] rd_id,
   input  logic [ID_W-1:0] wr_id,
   output logic            rd_match,
   output logic            wr_match,
   output logic [31:0]     rb
);

   logic [ID_W-1:0] val_q;
   logic [ID_W-1:0] msk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q <= '0;
         msk_q <= '0;
      end else if (wr) begin
         val_q <= wdata[ID_W-1:0];
         msk_q <= wdata[16+ID_W-1:16];
      end
   end

   always_comb begin
      rd_match = ((rd_id ^ val_q) & msk_q) == '0;
      wr_match = ((wr_id ^ val_q) & msk_q) == '0;
      rb       = {16'(msk_q), 16'(val_q)};
   end

endmodule

// File: rtl/mcpc_event_sel.sv
module mcpc_event_sel
   import mcpc_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctl_wr,
   input  logic [7:0]           wr_sel,
   input  logic [EVT_LINES-1:0] ev,
   input  logic                 rd_match,
   input  logic                 wr_match,
   output logic                 hit,
   output logic [7:0]           sel_o
);

   logic [7:0] sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= EC_CYCLES;
      else if (ctl_wr) sel_q <= wr_sel;
   end

   // the held selector decides the hit; a write lands only at the edge
   always_comb begin
      unique case (sel_q)
         EC_CYCLES: hit = 1'b1;
         EC_RD_ACC: hit = ev[LN_RD_ACC];
         EC_WR_ACC: hit = ev[LN_WR_ACC];
         EC_RD_CMD: hit = ev[LN_RD_CMD];
         EC_WR_CMD: hit = ev[LN_WR_CMD];
         EC_PRECH:  hit = ev[LN_PRECH];
         EC_ACTV:   hit = ev[LN_ACTV];
         EC_REFR:   hit = ev[LN_REFR];
         EC_RD_ID:  hit = ev[LN_RD_ACC] & rd_match;
         EC_WR_ID:  hit = ev[LN_WR_ACC] & wr_match;
         default:   hit = 1'b0;
      endcase
      sel_o = sel_q;
   end

endmodule

// File: rtl/mcpc_counter.sv
module mcpc_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic             wr_clr,
   input  logic             wr_en,
   input  logic             hit,
   output logic [CNT_W-1:0] cnt_o,
   output logic             en_o,
   output logic             ovf_o,
   output logic             wrap_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             en_q;
   logic             ovf_q;
   logic             do_clr;
   logic             bump;
   logic             at_top;

   always_comb begin
      do_clr = ctl_wr & wr_clr;
      bump   = en_q & hit & ~do_clr;
      at_top = &cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         en_q  <= 1'b0;
         ovf_q <= 1'b0;
      end else begin
         if (do_clr) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
         end else if (bump) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (at_top) ovf_q <= 1'b1;
         end
         if (ctl_wr) en_q <= wr_en;
      end
   end

   always_comb begin
      cnt_o  = cnt_q;
      en_o   = en_q;
      ovf_o  = ovf_q;
      wrap_o = bump & at_top;
   end

endmodule

// File: rtl/mc_perf_counters.sv
module mc_perf_counters
   import mcpc_pkg::*;
#(
   parameter int NUM_CNT = 4,
   parameter int CNT_W   = 32,
   parameter int ID_W    = 16,
   parameter int ADDR_W  = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic                 reg_we,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic [EVT_LINES-1:0] evt_pulse,
   input  logic [ID_W-1:0]      rd_axi_id,
   input  logic [ID_W-1:0]      wr_axi_id,
   output logic                 irq
);

   // only counter 0 may request the interrupt
   localparam logic [NUM_CNT-1:0] IRQ_SRC = NUM_CNT'(1);
   localparam logic [ADDR_W-1:0]  FILT_ADR = ADDR_W'(OFS_FILTER);

   if (NUM_CNT < 2 || NUM_CNT > 4) begin : g_bad_num
      $fatal(1, "NUM_CNT must lie in 2..4");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $fatal(1, "CNT_W must lie in 2..32");
   end
   if (ID_W < 1 || ID_W > 16) begin : g_bad_id
      $fatal(1, "ID_W must lie in 1..16");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $fatal(1, "ADDR_W must be at least 6");
   end

   logic [NUM_CNT-1:0]            ctl_hit;
   logic [NUM_CNT-1:0]            val_hit;
   logic                          filt_hit;
   ctl_wr_t                       cw;
   logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;
   logic [NUM_CNT-1:0][7:0]       sel_v;
   logic [NUM_CNT-1:0]            en_v;
   logic [NUM_CNT-1:0]            ovf_v;
   logic [NUM_CNT-1:0]            wrap_v;
   logic                          rd_match;
   logic                          wr_match;
   logic [31:0]                   filt_rb;
   logic                          irq_q;

   // address decode and write-field extraction
   always_comb begin
      for (int i = 0; i < NUM_CNT; i++) begin
         ctl_hit[i] = reg_addr == ADDR_W'(4 * i);
         val_hit[i] = reg_addr == ADDR_W'(OFS_VAL_BASE + 4 * i);
      end
      filt_hit = reg_addr == FILT_ADR;
      cw.sel   = reg_wdata[CTL_SEL_LSB +: 8];
      cw.en    = reg_wdata[CTL_EN_BIT];
      cw.clr   = reg_wdata[CTL_CLR_BIT];
   end

   mcpc_id_filter #(.ID_W(ID_W)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_we & filt_hit),
      .wdata    (reg_wdata),
      .rd_id    (rd_axi_id),
      .wr_id    (wr_axi_id),
      .rd_match (rd_match),
      .wr_match (wr_match),
      .rb       (filt_rb)
   );

   for (genvar g = 0; g < NUM_CNT; g++) begin : g_slice
      logic       hit;
      logic [7:0] sel;

      if (g == 0) begin : g_cycles
         assign hit = 1'b1;
         assign sel = EC_CYCLES;
      end else begin : g_event
         mcpc_event_sel u_sel (
            .clk      (clk),
            .rst_n    (rst_n),
            .ctl_wr   (reg_we & ctl_hit[g]),
            .wr_sel   (cw.sel),
            .ev       (evt_pulse),
            .rd_match (rd_match),
            .wr_match (wr_match),
            .hit      (hit),
            .sel_o    (sel)
         );
      end

      mcpc_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .ctl_wr (reg_we & ctl_hit[g]),
         .wr_clr (cw.clr),
         .wr_en  (cw.en),
         .hit    (hit),
         .cnt_o  (cnt_val[g]),
         .en_o   (en_v[g]),
         .ovf_o  (ovf_v[g]),
         .wrap_o (wrap_v[g])
      );

      assign sel_v[g] = sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(wrap_v & IRQ_SRC);
   end

   // read mux; the clear bit always reads back as zero
   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (ctl_hit[i]) reg_rdata = {sel_v[i], 21'd0, en_v[i], 1'b0, ovf_v[i]};
         if (val_hit[i]) reg_rdata = 32'(cnt_val[i]);
      end
      if (filt_hit) reg_rdata = filt_rb;
   end

   assign irq = irq_q;

endmodule

// File: rtl/mcpc_checker.sv
module mcpc_checker #(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_we,
   input logic              clr_bit,
   input logic [31:0]       reg_rdata,
   input logic              irq,
   input logic [CNT_W-1:0]  cnt0,
   input logic [CNT_W-1:0]  cnt1,
   input logic              en0,
   input logic              en1,
   input logic              ovf0,
   input logic              ovf1
);

   logic wr0, wr1;
   assign wr0 = reg_we && reg_addr == ADDR_W'(0);
   assign wr1 = reg_we && reg_addr == ADDR_W'(4);

   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr0 && clr_bit) |=> (cnt0 == '0 && !ovf0));

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!en1 && !wr1) |=> $stable(cnt1));

   assert_cycles_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en0 && !wr0) |=> cnt0 == $past(cnt0) + CNT_W'(1));

   assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf1 && !(wr1 && clr_bit)) |=> ovf1);

   assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   assert_irq_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ovf0 && cnt0 == '0));

   assert_clr_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(0)) |-> !reg_rdata[1]);

   assert_unmapped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'('h34)) |-> reg_rdata == '0);

endmodule

bind mc_perf_counters mcpc_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_we    (reg_we),
   .clr_bit   (reg_wdata[1]),
   .reg_rdata (reg_rdata),
   .irq       (irq),
   .cnt0      (cnt_val[0]),
   .cnt1      (cnt_val[1]),
   .en0       (en_v[0]),
   .en1       (en_v[1]),
   .ovf0      (ovf_v[0]),
   .ovf1      (ovf_v[1])
);

// File: tb/mc_perf_counters_tb.sv
module mc_perf_counters_tb;

   localparam int NC = 4;
   localparam int CW = 10;
   localparam int AW = 8;
   localparam int unsigned TOP = (1 << CW) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [6:0]  evt = '0;
   logic [15:0] rid = '0;
   logic [15:0] wid = '0;
   logic        irq;

   always #10 clk = ~clk;

   mc_perf_counters #(.NUM_CNT(NC), .CNT_W(CW), .ID_W(16), .ADDR_W(AW)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .evt_pulse (evt),
      .rd_axi_id (rid),
      .wr_axi_id (wid),
      .irq       (irq)
   );

   // reference state
   int unsigned m_cnt [NC];
   bit          m_en  [NC];
   bit          m_ovf [NC];
   bit [7:0]    m_sel [NC];
   bit          m_h   [NC];
   bit [15:0]   m_fv, m_fm;
   bit          m_irq;

   int    n_vec = 0;
   int    n_bad = 0;
   int    cyc   = 0;
   int    k     = 0;
   bit    done  = 1'b0;
   bit    ev_on = 1'b0;
   string tag   = "R1";
   logic [15:0] lfsr = 16'hACE1;

   function automatic bit m_hit(bit [7:0] s);
      bit ridok, widok;
      ridok = ((rid ^ m_fv) & m_fm) == 16'h0;
      widok = ((wid ^ m_fv) & m_fm) == 16'h0;
      case (s)
         8'h00:   return 1'b1;
         8'h04:   return evt[0];
         8'h05:   return evt[1];
         8'h20:   return evt[2];
         8'h21:   return evt[3];
         8'h31:   return evt[4];
         8'h32:   return evt[5];
         8'h37:   return evt[6];
         8'h41:   return evt[0] && ridok;
         8'h42:   return evt[1] && widok;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [31:0] m_read(logic [AW-1:0] a);
      int ai;
      ai = int'(a);
      if (ai % 4 != 0) return 32'h0;
      if (ai < NC * 4) return {m_sel[ai/4], 21'd0, m_en[ai/4], 1'b0, m_ovf[ai/4]};
      if (ai >= 'h20 && ai < 'h20 + NC * 4) return m_cnt[(ai - 'h20) / 4];
      if (ai == 'h30) return {m_fm, m_fv};
      return 32'h0;
   endfunction

   // reference update at each edge, comparison 15 ns later
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NC; i++) begin
            m_cnt[i] = 0; m_en[i] = 0; m_ovf[i] = 0; m_sel[i] = 0;
         end
         m_fv = 0; m_fm = 0; m_irq = 0;
      end else begin
         for (int i = 0; i < NC; i++) m_h[i] = (i == 0) ? 1'b1 : m_hit(m_sel[i]);
         m_irq = 1'b0;
         for (int i = 0; i < NC; i++) begin
            bit w;
            w = reg_we && int'(reg_addr) == 4 * i;
            if (w && reg_wdata[1]) begin
               m_cnt[i] = 0; m_ovf[i] = 0;
            end else if (m_en[i] && m_h[i]) begin
               if (m_cnt[i] == TOP) begin
                  m_cnt[i] = 0; m_ovf[i] = 1;
                  if (i == 0) m_irq = 1'b1;
               end else begin
                  m_cnt[i] = m_cnt[i] + 1;
               end
            end
            if (w) begin
               m_en[i]  = reg_wdata[2];
               m_sel[i] = (i == 0) ? 8'h00 : reg_wdata[31:24];
            end
         end
         if (reg_we && int'(reg_addr) == 'h30) begin
            m_fv = reg_wdata[15:0];
            m_fm = reg_wdata[31:16];
         end
      end
      #15;
      if (!done) begin
         n_vec++;
         if (reg_rdata !== m_read(reg_addr)) begin
            n_bad++;
            $display("FAIL %s addr=%h rdata=%h expected=%h", tag, reg_addr, reg_rdata, m_read(reg_addr));
         end
         n_vec++;
         if (irq !== m_irq) begin
            n_bad++;
            $display("FAIL R10 (%s) irq=%b expected=%b", tag, irq, m_irq);
         end
      end
   end

   // controller event stimulus
   always @(negedge clk) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (ev_on) begin
         evt = lfsr[6:0] ^ lfsr[13:7];
         rid = {lfsr[3] ? 8'h12 : 8'h34, lfsr[1] ? 8'h34 : lfsr[15:8]};
         wid = {lfsr[5] ? 8'h12 : 8'h56, lfsr[2] ? 8'h34 : lfsr[14:7]};
      end else begin
         evt = '0;
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL %s watchdog cycles=%0d expected<=%0d", tag, cyc, 20000);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   task automatic idle(input int n);
      for (int j = 0; j < n; j++) begin
         @(negedge clk);
         reg_we   = 1'b0;
         reg_addr = AW'((k * 4) % 64);
         k++;
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we    = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   initial begin
      // R1: reset state swept over the whole map
      tag = "R1";
      idle(4);
      rst_n = 1'b1;
      idle(20);

      // R6: cycle counter ignores a written selector
      tag = "R6";
      wr(8'h00, 32'h5500_0006);
      idle(30);

      // R7: event codes, including unknown ones
      tag = "R7";
      ev_on = 1'b1;
      wr(8'h04, 32'h0400_0006);
      wr(8'h08, 32'h2000_0006);
      wr(8'h0C, 32'h9900_0006);
      idle(150);
      wr(8'h04, 32'h3100_0006);
      wr(8'h08, 32'h3200_0006);
      wr(8'h0C, 32'h3700_0006);
      idle(100);
      wr(8'h04, 32'h0500_0006);
      wr(8'h08, 32'h2100_0006);
      wr(8'h0C, 32'h3F00_0006);
      idle(100);

      // R8: ID filter with partial, zero and full masks
      tag = "R8";
      wr(8'h30, 32'hFF00_1200);
      wr(8'h04, 32'h4100_0006);
      wr(8'h08, 32'h4200_0006);
      idle(200);
      wr(8'h30, 32'h0000_ABCD);
      idle(100);
      wr(8'h30, 32'hFFFF_1234);
      idle(120);

      // R5: disabled counter holds its value
      tag = "R5";
      wr(8'h04, 32'h4100_0000);
      idle(60);

      // R11: rewrite without clear keeps the count
      tag = "R11";
      wr(8'h08, 32'h4200_0004);
      idle(30);
      wr(8'h08, 32'h2000_0004);
      idle(30);

      // R4: clear and restart
      tag = "R4";
      wr(8'h04, 32'h2000_0006);
      idle(20);

      // R9 / R10: wraps of counter 1 and counter 0
      tag = "R9";
      wr(8'h04, 32'h0000_0006);
      idle(1100);
      tag = "R10";
      wr(8'h00, 32'h0000_0006);
      idle(1100);
      tag = "R9";
      wr(8'h04, 32'h0000_0004);
      idle(20);
      wr(8'h04, 32'h0000_0002);
      idle(20);

      // R2: writes to unmapped, read-only and unaligned addresses
      tag = "R2";
      wr(8'h34, 32'hFFFF_FFFF);
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h22, 32'hFFFF_FFFF);
      wr(8'h20, 32'h0000_0000);
      wr(8'h31, 32'hFFFF_FFFF);
      wr(8'h3C, 32'hFFFF_FFFF);
      idle(20);

      // R3: field layout, stray bits and overflow bit not writable
      tag = "R3";
      wr(8'h0C, 32'hAB7F_FFFF);
      idle(20);

      ev_on = 1'b0;
      idle(4);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule